// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single transfer requests from inside the chip into bus cycles on a 16-bit external bus whose pins carry the address first and the data afterwards. Each cycle runs through the states T1, T2, T3 and T4. Slow slaves stretch the cycle with wait states (TW) by holding READY low. The block drives the address latch strobe, the read, write and data-enable strobes, the transceiver direction, the memory-or-I/O select and the two byte-lane qualifiers, which are the high-byte enable and address bit 0.

A second bus master can take the bus through a HOLD input. HOLD is synchronised inside the block. The bus is granted only between cycles. While the bus is granted, the block floats its data pins and control strobes, and it shows this through output-enable signals rather than tri-state nets. A word access to an odd address is not split into two byte cycles. The block refuses it and returns an error response.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, ale_o=0, rd_no=1, wr_no=1, den_no=1, hlda_o=0, ad_oe_o=0 and req_ready_o=1.
- R2: In T1, the first cycle after a request is accepted, ale_o=1 and ad_oe_o=1. ad_o carries address bits 15:0. a_hi_o carries address bits 19:16 for a memory access and 0 for an I/O access. ale_o is never high in two cycles running.
- R3: For a read, rd_no is low in T2, T3 and every TW, and ad_oe_o is low in those states. rsp_rdata_o returns the ad_i value sampled on the clock edge that ends the last T3 or TW, and rsp_valid_o is high for exactly the T4 cycle.
- R4: READY is sampled on the edge that ends T3 and on the edge that ends each TW. If it is low, a further TW follows. If it is high, T4 follows.
- R5: For a write, wr_no is low in T2, T3 and every TW. ad_oe_o stays high and ad_o carries the write data from T2 through T4. rsp_valid_o is high in T4.
- R6: den_no (active low) goes low at the falling clock edge in the middle of T2 and goes high again at the falling edge in the middle of T4.
- R7: dt_r_o is 1 for a write and 0 for a read. It is valid from the cycle in which the request is accepted through T4.
- R8: m_io_o is 1 for memory and 0 for I/O. It is valid from the accepting cycle, which is the previous T4 or an idle cycle, through T4 of the cycle itself.
- R9: The byte lanes are given by {bhe_no, address bit 0} as seen in T1: 00 is a whole word, 01 is the upper byte only, 10 is the lower byte at an even address, and 11 means no transfer.
- R10: HOLD passes through two flops. Sampled high in an idle cycle or in T4, it makes hlda_o=1 in the following cycle. While hlda_o=1: ad_oe_o=0, ctl_oe_o=0, ale_o=0, and req_ready_o=0.
- R11: A request offered while the bus is held starts no cycle. It is accepted in the first idle cycle after hlda_o falls.
- R12: A word request (req_word_i=1) to an odd address starts no bus cycle. In the next cycle rsp_valid_o=1 and rsp_err_o=1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_addr_i | input | 20 | Byte address |
| req_wdata_i | input | 16 | Write data, already placed on its byte lane |
| req_write_i | input | 1 | 1 write, 0 read |
| req_io_i | input | 1 | 1 I/O space, 0 memory |
| req_word_i | input | 1 | 1 word, 0 byte |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Request refused (misaligned word) |
| rsp_rdata_o | output | 16 | Read data |
| ad_o | output | 16 | Address/data pins, driven value |
| ad_i | input | 16 | Address/data pins, sampled value |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| a_hi_o | output | 4 | Upper address lines |
| ale_o | output | 1 | Address latch strobe, never floated |
| bhe_no | output | 1 | High-byte enable, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| den_no | output | 1 | Data transceiver enable, active low |
| dt_r_o | output | 1 | Transceiver direction, 1 transmit |
| m_io_o | output | 1 | 1 memory, 0 I/O |
| ctl_oe_o | output | 1 | Drive enable for the strobe and select outputs |
| ready_i | input | 1 | Slave ready |
| hold_i | input | 1 | Bus request from another master (asynchronous) |
| hlda_o | output | 1 | Bus granted |

## Verification
The accepting clock edge starts T1, and ale_o and the address are checked one edge after acceptance. Each later bus state is checked one edge further on, so the bench samples every strobe 1 ns after the rising edge of the state it belongs to. den_no changes on a falling edge. Sampling just after the rising edge of T2 therefore still sees it inactive, sampling in T3 and T4 sees it active, and sampling in the following cycle sees it inactive again. The HOLD path is counted edge by edge: hlda_o is checked low after one and two edges and high after the third, and it is released with the same count.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_HLD
  } bus_st_e;

  // active-low high-byte enable from size and address bit 0
  function automatic logic lane_bhe_n(input logic word, input logic a0);
    return ~(word | a0);
  endfunction
endpackage

// File: rtl/bus_hold_sync.sv
module bus_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= async_i;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bus_den_neg.sv
module bus_den_neg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic den_act_o
);
  // falling-edge flop gives the half-cycle offset
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) den_act_o <= 1'b0;
    else den_act_o <= active_i;
  end
endmodule

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    hold_i,
  input  logic    ready_i,
  output bus_st_e state_o,
  output logic    can_accept_o
);
  bus_st_e st_q, st_d;

  assign can_accept_o = ((st_q == ST_IDLE) || (st_q == ST_T4)) && !hold_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_T4: begin
        if (hold_i) st_d = ST_HLD;
        else if (start_i) st_d = ST_T1;
        else st_d = ST_IDLE;
      end
      ST_T1: st_d = ST_T2;
      ST_T2: st_d = ST_T3;
      ST_T3, ST_TW: st_d = ready_i ? ST_T4 : ST_TW;
      ST_HLD: st_d = hold_i ? ST_HLD : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int HOLD_SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_word_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] a_hi_o,
  output logic              ale_o,
  output logic              bhe_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              den_no,
  output logic              dt_r_o,
  output logic              m_io_o,
  output logic              ctl_oe_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  bus_st_e st;
  logic hold_s, can_accept, accept, misalign, start, capture;
  logic in_cyc, data_ph, strobe_ph, den_act;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic wr_q, io_q, word_q, rsp_valid_q, rsp_err_q;

  bus_hold_sync #(.STAGES(HOLD_SYNC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(hold_i), .sync_o(hold_s)
  );

  assign accept   = req_valid_i & can_accept;
  assign misalign = req_word_i & req_addr_i[0];
  assign start    = accept & ~misalign;

  bus_cycle_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .hold_i(hold_s),
    .ready_i(ready_i), .state_o(st), .can_accept_o(can_accept)
  );

  assign in_cyc    = (st == ST_T1) || (st == ST_T2) || (st == ST_T3) ||
                     (st == ST_TW) || (st == ST_T4);
  assign strobe_ph = (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  assign data_ph   = strobe_ph || (st == ST_T4);
  assign capture   = ((st == ST_T3) || (st == ST_TW)) && ready_i;

  bus_den_neg u_den (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(strobe_ph), .den_act_o(den_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      word_q  <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      wr_q    <= req_write_i;
      io_q    <= req_io_i;
      word_q  <= req_word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      if (capture && !wr_q) rdata_q <= ad_i;
      rsp_valid_q <= capture | (accept & misalign);
      rsp_err_q   <= accept & misalign;
    end
  end

  assign req_ready_o = can_accept;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rdata_q;

  assign ale_o   = (st == ST_T1);
  assign ad_oe_o = (st == ST_T1) || (data_ph && wr_q);
  assign ad_o    = (st == ST_T1) ? addr_q[DATA_W-1:0] : wdata_q;
  assign a_hi_o  = ((st == ST_T1) && !io_q) ? addr_q[ADDR_W-1:DATA_W] : {HI_W{1'b0}};

  assign rd_no    = ~(strobe_ph & ~wr_q);
  assign wr_no    = ~(strobe_ph & wr_q);
  assign den_no   = ~den_act;
  assign bhe_no   = in_cyc ? lane_bhe_n(word_q, addr_q[0]) : 1'b1;
  // select and direction turn valid in the accepting cycle
  assign m_io_o   = start ? ~req_io_i : ~io_q;
  assign dt_r_o   = start ? req_write_i : wr_q;
  assign ctl_oe_o = (st != ST_HLD);
  assign hlda_o   = (st == ST_HLD);
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic ad_oe_o,
  input logic rd_no,
  input logic wr_no,
  input logic dt_r_o,
  input logic ctl_oe_o,
  input logic ready_i,
  input logic hlda_o,
  input logic rsp_valid_o,
  input logic rsp_err_o
);
  AST_ALE_DRIVES_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o); // R2
  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R2
  AST_RD_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!ad_oe_o && wr_no)); // R3
  AST_RD_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && !ready_i) |=> !rd_no); // R4
  AST_WR_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && !ready_i) |=> !wr_no); // R4
  AST_WR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (dt_r_o && ad_oe_o)); // R5
  AST_HLDA_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !ctl_oe_o)); // R10
  AST_HLDA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ale_o && rd_no && wr_no)); // R11
  AST_ERR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && !ale_o)); // R12
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ale_o(ale_o), .ad_oe_o(ad_oe_o),
  .rd_no(rd_no), .wr_no(wr_no), .dt_r_o(dt_r_o), .ctl_oe_o(ctl_oe_o),
  .ready_i(ready_i), .hlda_o(hlda_o), .rsp_valid_o(rsp_valid_o),
  .rsp_err_o(rsp_err_o)
);

// File: tb/mux_bus_seq_tb_top.sv
`timescale 1ns/100ps
module mux_bus_seq_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_write_i = 0, req_io_i = 0, req_word_i = 0;
  logic [19:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0, ad_i = '0;
  logic ready_i = 1'b1, hold_i = 1'b0;
  logic req_ready_o, rsp_valid_o, rsp_err_o, ad_oe_o, ale_o, bhe_no;
  logic rd_no, wr_no, den_no, dt_r_o, m_io_o, ctl_oe_o, hlda_o;
  logic [15:0] rsp_rdata_o, ad_o;
  logic [3:0] a_hi_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  mux_bus_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_write_i(req_write_i),
    .req_io_i(req_io_i), .req_word_i(req_word_i), .rsp_valid_o(rsp_valid_o),
    .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o), .ad_o(ad_o), .ad_i(ad_i),
    .ad_oe_o(ad_oe_o), .a_hi_o(a_hi_o), .ale_o(ale_o), .bhe_no(bhe_no), .rd_no(rd_no),
    .wr_no(wr_no), .den_no(den_no), .dt_r_o(dt_r_o), .m_io_o(m_io_o),
    .ctl_oe_o(ctl_oe_o), .ready_i(ready_i), .hold_i(hold_i), .hlda_o(hlda_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic offer(input logic [19:0] a, input logic wr, input logic io,
                       input logic word, input logic [15:0] wd);
    req_valid_i = 1; req_addr_i = a; req_write_i = wr; req_io_i = io;
    req_word_i = word; req_wdata_i = wd;
  endtask

  task automatic t_reset();
    chk("R1", "ale", ale_o, 0);
    chk("R1", "rd_n", rd_no, 1);
    chk("R1", "wr_n", wr_no, 1);
    chk("R1", "den_n", den_no, 1);
    chk("R1", "hlda", hlda_o, 0);
    chk("R1", "ad_oe", ad_oe_o, 0);
    chk("R1", "req_ready", req_ready_o, 1);
  endtask

  // memory byte read, even address, no waits
  task automatic t_read_plain();
    ready_i = 1; ad_i = 16'h00C3;
    offer(20'hA1234, 0, 0, 0, 16'h0);
    #1;
    chk("R8", "m_io early", m_io_o, 1);
    chk("R7", "dt_r early", dt_r_o, 0);
    step();
    req_valid_i = 0;
    chk("R2", "ale T1", ale_o, 1);
    chk("R2", "ad T1", ad_o, 16'h1234);
    chk("R2", "a_hi T1", a_hi_o, 4'hA);
    chk("R2", "ad_oe T1", ad_oe_o, 1);
    chk("R9", "lanes lower", {bhe_no, ad_o[0]}, 2'b10);
    step();
    chk("R3", "rd_n T2", rd_no, 0);
    chk("R3", "ad_oe T2", ad_oe_o, 0);
    chk("R6", "den_n early T2", den_no, 1);
    chk("R2", "ale T2", ale_o, 0);
    step();
    chk("R3", "rd_n T3", rd_no, 0);
    chk("R6", "den_n T3", den_no, 0);
    step();
    chk("R3", "rsp_valid T4", rsp_valid_o, 1);
    chk("R3", "rdata", rsp_rdata_o, 16'h00C3);
    chk("R3", "rd_n T4", rd_no, 1);
    chk("R6", "den_n T4", den_no, 0);
    chk("R8", "m_io T4", m_io_o, 1);
    chk("R7", "dt_r T4", dt_r_o, 0);
    step();
    chk("R6", "den_n after T4", den_no, 1);
    chk("R3", "rsp_valid after", rsp_valid_o, 0);
  endtask

  // I/O byte read, odd address, two wait states
  task automatic t_read_wait();
    ready_i = 1; ad_i = 16'h1111;
    offer(20'h30057, 0, 1, 0, 16'h0);
    step();
    req_valid_i = 0;
    chk("R2", "a_hi io", a_hi_o, 4'h0);
    chk("R9", "lanes upper", {bhe_no, ad_o[0]}, 2'b01);
    chk("R8", "m_io io", m_io_o, 0);
    step();
    ready_i = 0;
    step();
    chk("R4", "rd_n T3", rd_no, 0);
    step();
    chk("R4", "rd_n TW1", rd_no, 0);
    chk("R4", "no rsp TW1", rsp_valid_o, 0);
    step();
    chk("R4", "rd_n TW2", rd_no, 0);
    chk("R6", "den_n TW2", den_no, 0);
    ready_i = 1; ad_i = 16'h5A00;
    step();
    chk("R4", "rsp_valid after wait", rsp_valid_o, 1);
    chk("R3", "rdata wait", rsp_rdata_o, 16'h5A00);
    chk("R8", "m_io T4 io", m_io_o, 0);
    step();
    chk("R4", "idle rd_n", rd_no, 1);
  endtask

  // memory word write, even address
  task automatic t_write();
    ready_i = 1;
    offer(20'h24680, 1, 0, 1, 16'hBEEF);
    #1;
    chk("R7", "dt_r early", dt_r_o, 1);
    step();
    req_valid_i = 0;
    chk("R9", "lanes word", {bhe_no, ad_o[0]}, 2'b00);
    chk("R2", "ad T1 wr", ad_o, 16'h4680);
    step();
    chk("R5", "wr_n T2", wr_no, 0);
    chk("R5", "rd_n T2", rd_no, 1);
    chk("R5", "ad_oe T2", ad_oe_o, 1);
    chk("R5", "ad T2", ad_o, 16'hBEEF);
    chk("R7", "dt_r T2", dt_r_o, 1);
    step();
    chk("R5", "wr_n T3", wr_no, 0);
    step();
    chk("R5", "wr_n T4", wr_no, 1);
    chk("R5", "ad_oe T4", ad_oe_o, 1);
    chk("R5", "ad T4", ad_o, 16'hBEEF);
    chk("R5", "rsp_valid T4", rsp_valid_o, 1);
    step();
    chk("R5", "ad_oe idle", ad_oe_o, 0);
  endtask

  task automatic t_misalign();
    offer(20'h00011, 0, 0, 1, 16'h0);
    step();
    req_valid_i = 0;
    chk("R12", "rsp_valid", rsp_valid_o, 1);
    chk("R12", "rsp_err", rsp_err_o, 1);
    chk("R12", "ale", ale_o, 0);
    step();
    chk("R12", "rsp_valid clears", rsp_valid_o, 0);
    chk("R12", "no cycle", ale_o, 0);
    chk("R12", "rd_n", rd_no, 1);
  endtask

  // hold taken in idle, request offered while held
  task automatic t_hold_idle();
    hold_i = 1;
    step();
    chk("R10", "hlda edge1", hlda_o, 0);
    step();
    chk("R10", "hlda edge2", hlda_o, 0);
    step();
    chk("R10", "hlda edge3", hlda_o, 1);
    chk("R10", "ad_oe held", ad_oe_o, 0);
    chk("R10", "ctl_oe held", ctl_oe_o, 0);
    chk("R10", "req_ready held", req_ready_o, 0);
    offer(20'h00100, 0, 0, 0, 16'h0);
    step();
    chk("R11", "no ale held", ale_o, 0);
    step();
    chk("R11", "no ale held 2", ale_o, 0);
    hold_i = 0;
    step();
    chk("R10", "hlda rel1", hlda_o, 1);
    step();
    chk("R10", "hlda rel2", hlda_o, 1);
    step();
    chk("R10", "hlda rel3", hlda_o, 0);
    chk("R11", "no ale at release", ale_o, 0);
    chk("R11", "ctl_oe back", ctl_oe_o, 1);
    step();
    req_valid_i = 0;
    chk("R11", "pending starts", ale_o, 1);
    for (int i = 0; i < 4; i++) step();
    chk("R11", "cycle done", rd_no, 1);
  endtask

  // hold raised during a cycle is granted only after T4
  task automatic t_hold_cycle();
    ready_i = 1;
    offer(20'h00200, 0, 0, 0, 16'h0);
    step();
    req_valid_i = 0;
    hold_i = 1;
    step();
    step();
    chk("R10", "hlda in T3", hlda_o, 0);
    chk("R10", "rd_n still T3", rd_no, 0);
    step();
    chk("R10", "hlda in T4", hlda_o, 0);
    chk("R10", "req_ready T4", req_ready_o, 0);
    step();
    chk("R10", "hlda after T4", hlda_o, 1);
    chk("R10", "ad_oe after T4", ad_oe_o, 0);
    hold_i = 0;
    for (int i = 0; i < 3; i++) step();
    chk("R10", "hlda released", hlda_o, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog all requirements: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #7 rst_ni = 1'b1;
    step();
    t_reset();
    t_read_plain();
    t_read_wait();
    t_write();
    t_misalign();
    t_hold_idle();
    t_hold_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule